// File: doc/BRIEF.md
# Bit-Serial Feistel Block Cipher Core

This core encrypts one 96-bit block under a 96-bit key with a lightweight Feistel cipher. The cipher uses two 48-bit words per block, a two-word key schedule and 52 rounds. Every value enters and leaves one bit per clock. The round function and the key expansion also produce one bit per clock. Each 48-bit word sits in a circulating shift register. The rotated operands are read at fixed positions of that register, so the core needs no parallel rotator.

A host pulses `start` to begin an operation and chooses the chaining mode with it. The host then streams the key and the plaintext, and in chained mode it can first stream a fresh initialization value. When encryption ends, the core raises `done` for exactly one block length and presents the ciphertext on `dataOut`, one bit per cycle. In chained mode the next plaintext is mixed with the ciphertext that was just delivered. In independent mode every block stands alone. The key must be streamed again for every operation, which overwrites whatever the previous operation left behind.

Top module: `feistel_serial_core`

## Requirements
- R1: After reset `done` and `dataOut` are both 0.
- R2: A `start` pulse seen while idle begins an operation. In the load phase of 96 cycles the core samples key bit j on `keyIvIn` and plaintext bit j on `dataIn` in cycle j (j = 0 first, LSB first). Block bits 95:48 form the upper word. Key bits 47:0 form the first round key and key bits 95:48 form the second.
- R3: The ciphertext equals 52 rounds of the following function. The new upper word is (U rotl 1 AND U rotl 8) XOR (U rotl 2) XOR L XOR roundkey, and the old upper word becomes the new lower word. The round keys follow k[i+2] = k[i] XOR (k[i+1] rotr 3) XOR (k[i+1] rotr 4) XOR (2^48 - 4) XOR z[i]. The constant sequence z is 10101111011100000011010010011000101000010001111110010110110011, read left to right as z[0], z[1], and so on.
- R4: Take the clock edge that samples `start` as edge 0. `done` is first seen high after edge 96 + 52*48 = 2592. When an initialization value is loaded, it is first seen high after edge 2688.
- R5: `done` stays high for exactly 96 consecutive cycles. In the k-th of those cycles `dataOut` carries ciphertext bit k, starting with bit 0.
- R6: `dataOut` is 0 whenever `done` is 0.
- R7: With `cbcMode`=1 and `ivRestart`=1 at start, the core takes 96 initialization bits on `keyIvIn` before the load phase and XORs them into the plaintext before encryption. Any earlier chaining state is discarded.
- R8: With `cbcMode`=1 and `ivRestart`=0, the plaintext is XORed with the ciphertext of the previous operation before encryption.
- R9: With `cbcMode`=0, the result depends only on the key and the plaintext of the current operation, and `ivRestart` is ignored.
- R10: A `start` pulse while an operation is in progress has no effect on its result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the core is idle |
| cbcMode | input | 1 | Selects chained mode, sampled with start |
| ivRestart | input | 1 | In chained mode, loads a fresh initialization value first |
| keyIvIn | input | 1 | Serial key bits, or initialization bits in the first phase |
| dataIn | input | 1 | Serial plaintext bits |
| dataOut | output | 1 | Serial ciphertext bits while done is high, otherwise 0 |
| done | output | 1 | High for the 96 output cycles of a finished operation |

## Verification
The bench builds the core with its default word width of 48 and 52 rounds, which is the only setting its bit-parallel reference model covers. At that size one block costs about 2700 cycles. This makes room for a sweep of corner keys and plaintexts (all zeros, all ones, single set bits) and of pseudo-random vectors, each checked bit-exactly. The sweep also covers chained runs with and without a fresh initialization value, a return to independent mode after chaining, and a start pulse injected mid-encryption. Each run also checks the exact latency to `done`, the length of the output window and the silence of `dataOut` outside that window.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  // Strobes from the sequencer to the serial datapath
  typedef struct packed {
    logic ivShift;      // shift initialization bits into the block chain
    logic loadShift;    // shift key and plaintext in
    logic chainXor;     // mix circulating previous block into plaintext
    logic roundStep;    // one serial round step
    logic phase;        // word-role swap, toggles every round
    logic keyConst;     // constant bit (round constant XOR z) for this bit slot
    logic unloadShift;  // shift ciphertext out while circulating it
  } fsc_strobe_t;

endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
#(
  parameter int WORD   = 48,
  parameter int ROUNDS = 52,
  parameter int ZLEN   = 62,
  parameter logic [ZLEN-1:0] ZSEQ = 62'b10101111011100000011010010011000101000010001111110010110110011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cbcMode,
  input  logic        ivRestart,
  output fsc_strobe_t stb,
  output logic        done
);

  localparam int BLOCK = 2 * WORD;
  localparam int CW    = $clog2(BLOCK);
  localparam int RW    = $clog2(ROUNDS + 1);
  localparam int ZW    = $clog2(ZLEN);
  localparam logic [CW-1:0] BLK_LAST = CW'(BLOCK - 1);
  localparam logic [CW-1:0] WRD_LAST = CW'(WORD - 1);
  localparam logic [RW-1:0] RND_LAST = RW'(ROUNDS - 1);
  localparam logic [ZW-1:0] Z_LAST   = ZW'(ZLEN - 1);

  typedef enum logic [2:0] {S_IDLE, S_IV, S_LOAD, S_ROUND, S_OUT} fsc_state_t;

  fsc_state_t    state;
  logic [CW-1:0] bitCnt;
  logic [RW-1:0] roundCnt;
  logic [ZW-1:0] zCnt;
  logic          phase;
  logic          cbcHeld;
  logic          zBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      roundCnt <= '0;
      zCnt     <= '0;
      phase    <= 1'b0;
      cbcHeld  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            cbcHeld  <= cbcMode;
            bitCnt   <= '0;
            roundCnt <= '0;
            zCnt     <= '0;
            phase    <= 1'b0;
            state    <= (cbcMode && ivRestart) ? S_IV : S_LOAD;
          end
        end
        S_IV: begin
          if (bitCnt == BLK_LAST) begin
            bitCnt <= '0;
            state  <= S_LOAD;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_LOAD: begin
          if (bitCnt == BLK_LAST) begin
            bitCnt <= '0;
            state  <= S_ROUND;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_ROUND: begin
          if (bitCnt == WRD_LAST) begin
            bitCnt   <= '0;
            phase    <= ~phase;
            roundCnt <= roundCnt + 1'b1;
            zCnt     <= (zCnt == Z_LAST) ? '0 : zCnt + 1'b1;
            if (roundCnt == RND_LAST) state <= S_OUT;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_OUT: begin
          if (bitCnt == BLK_LAST) begin
            bitCnt <= '0;
            state  <= S_IDLE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    zBit            = ZSEQ[Z_LAST - zCnt];
    stb.ivShift     = (state == S_IV);
    stb.loadShift   = (state == S_LOAD);
    stb.chainXor    = (state == S_LOAD) && cbcHeld;
    stb.roundStep   = (state == S_ROUND);
    stb.phase       = phase;
    // constant word is all ones except bit 1 (zero) and bit 0 (z bit)
    if (bitCnt == '0)             stb.keyConst = zBit;
    else if (bitCnt == CW'(1))    stb.keyConst = 1'b0;
    else                          stb.keyConst = 1'b1;
    stb.unloadShift = (state == S_OUT);
    done            = (state == S_OUT);
  end

  assert_round_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ROUND) |-> (roundCnt < RW'(ROUNDS)));

  assert_round_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ROUND) |=> (state == S_ROUND || state == S_OUT));

  assert_out_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OUT) |-> (bitCnt <= BLK_LAST));

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && start) |=> (state != S_IV || $past(state) == S_IV));

  generate
    if (ROUNDS % 2 == 0) begin : g_even
      assert_phase_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OUT) |-> !phase);
    end
  endgenerate

endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int WORD = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fsc_strobe_t stb,
  input  logic        keyIvIn,
  input  logic        dataIn,
  output logic        dataOut
);

  // regA/regB: block words; key0/key1: key words. Roles swap with stb.phase.
  logic [WORD-1:0] regA, regB, key0, key1;
  logic [WORD-1:0] upper, lower, kRound, kCirc;
  logic            newBit, newKey, chainIn;

  always_comb begin
    upper  = stb.phase ? regB : regA;
    lower  = stb.phase ? regA : regB;
    kRound = stb.phase ? key1 : key0;
    kCirc  = stb.phase ? key0 : key1;
    // taps: position WORD-1 = rotl 1, WORD-2 = rotl 2, WORD-8 = rotl 8
    newBit = (upper[WORD-1] & upper[WORD-8]) ^ upper[WORD-2] ^ lower[0] ^ kRound[0];
    // taps: position 3 = rotr 3, position 4 = rotr 4
    newKey = kRound[0] ^ kCirc[3] ^ kCirc[4] ^ stb.keyConst;
    if (stb.ivShift)        chainIn = keyIvIn;
    else if (stb.loadShift) chainIn = dataIn ^ (stb.chainXor & regB[0]);
    else                    chainIn = regB[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regA <= '0;
      regB <= '0;
    end else if (stb.ivShift || stb.loadShift || stb.unloadShift) begin
      regA <= {chainIn, regA[WORD-1:1]};
      regB <= {regA[0], regB[WORD-1:1]};
    end else if (stb.roundStep) begin
      if (!stb.phase) begin
        regA <= {regA[0], regA[WORD-1:1]};
        regB <= {newBit, regB[WORD-1:1]};
      end else begin
        regB <= {regB[0], regB[WORD-1:1]};
        regA <= {newBit, regA[WORD-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key0 <= '0;
      key1 <= '0;
    end else if (stb.loadShift) begin
      key1 <= {keyIvIn, key1[WORD-1:1]};
      key0 <= {key1[0], key0[WORD-1:1]};
    end else if (stb.roundStep) begin
      if (!stb.phase) begin
        key1 <= {key1[0], key1[WORD-1:1]};
        key0 <= {newKey, key0[WORD-1:1]};
      end else begin
        key0 <= {key0[0], key0[WORD-1:1]};
        key1 <= {newKey, key1[WORD-1:1]};
      end
    end
  end

  assign dataOut = stb.unloadShift & regB[0];

endmodule

// File: rtl/feistel_serial_core.sv
module feistel_serial_core
  import fsc_pkg::*;
#(
  parameter int WORD   = 48,
  parameter int ROUNDS = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cbcMode,
  input  logic ivRestart,
  input  logic keyIvIn,
  input  logic dataIn,
  output logic dataOut,
  output logic done
);

  fsc_strobe_t stb;

  fsc_ctrl #(.WORD(WORD), .ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cbcMode(cbcMode),
    .ivRestart(ivRestart), .stb(stb), .done(done)
  );

  fsc_datapath #(.WORD(WORD)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .keyIvIn(keyIvIn),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  assert_quiet_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !dataOut);

endmodule

// File: tb/feistel_serial_core_bench.sv
module feistel_serial_core_bench;

  localparam logic [61:0] ZREF = 62'b10101111011100000011010010011000101000010001111110010110110011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cbcMode = 1'b0, ivRestart = 1'b0, keyIvIn = 1'b0, dataIn = 1'b0;
  logic dataOut, done;

  int total = 0;
  int failed = 0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  feistel_serial_core u_feistel_serial_core (
    .clk(clk), .rst_n(rst_n), .start(start), .cbcMode(cbcMode),
    .ivRestart(ivRestart), .keyIvIn(keyIvIn), .dataIn(dataIn),
    .dataOut(dataOut), .done(done)
  );

  function automatic logic [47:0] rl(input logic [47:0] v, input int s);
    return (v << s) | (v >> (48 - s));
  endfunction

  function automatic logic [47:0] rr(input logic [47:0] v, input int s);
    return (v >> s) | (v << (48 - s));
  endfunction

  // bit-parallel reference of the cipher
  function automatic logic [95:0] refEnc(input logic [95:0] pt, input logic [95:0] key);
    logic [47:0] ks [0:51];
    logic [47:0] x, y, t;
    ks[0] = key[47:0];
    ks[1] = key[95:48];
    for (int i = 0; i < 50; i++)
      ks[i+2] = ks[i] ^ rr(ks[i+1], 3) ^ rr(ks[i+1], 4) ^ ~48'd3 ^ {47'd0, ZREF[61-i]};
    x = pt[95:48];
    y = pt[47:0];
    for (int r = 0; r < 52; r++) begin
      t = x;
      x = y ^ (rl(x, 1) & rl(x, 8)) ^ rl(x, 2) ^ ks[r];
      y = t;
    end
    return {x, y};
  endfunction

  task automatic nextRand(output logic [95:0] v);
    for (int h = 0; h < 2; h++) begin
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 7);
      rs = rs ^ (rs << 17);
      if (h == 0) v[63:0] = rs; else v[95:64] = rs[31:0];
    end
  endtask

  task automatic check(input logic ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic runBlock(input logic cbc, input logic ivr, input logic [95:0] iv,
                          input logic [95:0] pt, input logic [95:0] key, input logic poke,
                          output logic [95:0] ct, output int lat, output int dlen,
                          output logic quiet);
    int n;
    quiet = 1'b1;
    ct = '0;
    @(negedge clk);
    start = 1'b1; cbcMode = cbc; ivRestart = ivr;
    @(negedge clk);
    start = 1'b0; cbcMode = 1'b0; ivRestart = 1'b0;
    n = 0;
    if (cbc && ivr) begin
      for (int j = 0; j < 96; j++) begin
        keyIvIn = iv[j];
        dataIn = ~iv[j];
        @(negedge clk); n++;
        if (done || dataOut) quiet = 1'b0;
      end
    end
    for (int j = 0; j < 96; j++) begin
      keyIvIn = key[j];
      dataIn = pt[j];
      @(negedge clk); n++;
      if (done || dataOut) quiet = 1'b0;
    end
    keyIvIn = 1'b0; dataIn = 1'b0;
    while (!done && n < 4000) begin
      if (dataOut) quiet = 1'b0;
      if (poke && n == 500) begin
        start = 1'b1; cbcMode = 1'b1; ivRestart = 1'b1;
      end else begin
        start = 1'b0; cbcMode = 1'b0; ivRestart = 1'b0;
      end
      @(negedge clk); n++;
    end
    start = 1'b0; cbcMode = 1'b0; ivRestart = 1'b0;
    lat = n;
    dlen = 0;
    while (done && dlen < 200) begin
      if (dlen < 96) ct[dlen] = dataOut;
      dlen++;
      @(negedge clk);
    end
    if (dataOut) quiet = 1'b0;
  endtask

  task automatic blockChecks(input string tag, input logic [95:0] ct, input logic [95:0] exp,
                             input int lat, input int expLat, input int dlen, input logic quiet);
    check(ct == exp, {tag, " R3 ciphertext"}, ct, exp);
    check(lat == expLat, {tag, " R4 latency"}, 96'(lat), 96'(expLat));
    check(dlen == 96, {tag, " R5 output window"}, 96'(dlen), 96'd96);
    check(quiet, {tag, " R6 dataOut quiet outside window"}, 96'(quiet), 96'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [95:0] ct, pt, key, iv, prev, exp;
    int lat, dlen;
    logic quiet;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done after reset", 96'(done), 96'd0);
    check(dataOut == 1'b0, "R1 dataOut after reset", 96'(dataOut), 96'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && dataOut == 1'b0, "R1 idle outputs", {94'd0, done, dataOut}, 96'd0);

    // R2 R3 R4 R5 R6: corner vectors in independent mode
    for (int v = 0; v < 6; v++) begin
      case (v)
        0: begin pt = '0;              key = '0;              end
        1: begin pt = '1;              key = '1;              end
        2: begin pt = 96'd1;           key = '0;              end
        3: begin pt = '0;              key = 96'd1 << 95;     end
        4: begin pt = 96'd1 << 48;     key = 96'd1 << 47;     end
        default: begin nextRand(pt);   nextRand(key);         end
      endcase
      runBlock(1'b0, 1'b0, '0, pt, key, 1'b0, ct, lat, dlen, quiet);
      blockChecks("R2 ecb", ct, refEnc(pt, key), lat, 2592, dlen, quiet);
    end

    // R9: repeat with ivRestart high in independent mode, same inputs, same result
    runBlock(1'b0, 1'b1, '1, pt, key, 1'b0, ct, lat, dlen, quiet);
    blockChecks("R9 repeat", ct, refEnc(pt, key), lat, 2592, dlen, quiet);

    // R7: chained mode starting from a fresh initialization value
    nextRand(iv); nextRand(pt); nextRand(key);
    runBlock(1'b1, 1'b1, iv, pt, key, 1'b0, ct, lat, dlen, quiet);
    exp = refEnc(pt ^ iv, key);
    blockChecks("R7 cbc first", ct, exp, lat, 2688, dlen, quiet);
    prev = ct;

    // R8: chained continuation with changing keys
    for (int b = 0; b < 2; b++) begin
      nextRand(pt); nextRand(key);
      runBlock(1'b1, 1'b0, '0, pt, key, 1'b0, ct, lat, dlen, quiet);
      exp = refEnc(pt ^ prev, key);
      blockChecks("R8 cbc chain", ct, exp, lat, 2592, dlen, quiet);
      prev = ct;
    end

    // R7: a new initialization value overrides the chain
    nextRand(iv); nextRand(pt);
    runBlock(1'b1, 1'b1, iv, pt, key, 1'b0, ct, lat, dlen, quiet);
    blockChecks("R7 cbc restart", ct, refEnc(pt ^ iv, key), lat, 2688, dlen, quiet);

    // R9: independent mode after chaining ignores the previous ciphertext
    runBlock(1'b0, 1'b0, '0, pt, key, 1'b0, ct, lat, dlen, quiet);
    blockChecks("R9 ecb after cbc", ct, refEnc(pt, key), lat, 2592, dlen, quiet);

    // R10: start pulse during the rounds is ignored
    nextRand(pt); nextRand(key);
    runBlock(1'b0, 1'b0, '0, pt, key, 1'b1, ct, lat, dlen, quiet);
    blockChecks("R10 busy start", ct, refEnc(pt, key), lat, 2592, dlen, quiet);
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10 no extra operation", 96'(done), 96'd0);

    finishRun();
  end

endmodule